// File: doc/BRIEF.md
# Programmable Memory Pointer Controller

This block is an auto-incrementing memory access port that a DSP reaches through a small register window. The window has one setup register and a parameterised number of data registers. Each data register owns two pointer contexts, one for reads and one for writes. A pointer context holds a 16-bit address and a 16-bit mode word. When a data register is accessed, the matching context sends the access to either an external ROM or a DRAM, and the pointer then advances on its own.

Configuring a pointer takes two writes to the setup register: an address word first, then a mode word. The mode word names its target context through the data-register index presented with it and through one context-select bit. Reading the setup register returns the current address of the context accessed most recently, and it also flips the setup sequencer between the address phase and the mode phase. Software uses this side effect to resynchronise the sequence.

In ROM mode the low mode bits act as a bank, and the bank carries upward when the address runs past its top, so the address never wraps. In DRAM mode the pointer moves by a step encoded in the mode word. A data register whose context is not configured behaves as a plain storage register.

Top module: `pmem_ptr_ctrl`

## Requirements
- R1: After reset, `rvalid`, `rom_en`, `dram_en` and `mode_err` are 0. Every context is unconfigured and every plain storage value is 0. The setup sequencer expects an address word, and the last-accessed context is the read context of data register 0, whose address is 0.
- R2: A setup write in the address phase stages the address and moves to the mode phase. A setup write in the mode phase commits the staged address and the written mode word to the context of data register `ptr_idx`, then returns to the address phase. Mode bit 10 picks the context: 0 means read, 1 means write.
- R3: A setup read flips the address/mode phase. One cycle after the request it returns, with `rvalid` high, the current address of the last-accessed context. The last-accessed context is updated by every data read (read context), every data write (write context) and every mode commit.
- R4: A data read on a configured ROM-mode read context drives `rom_en` with `rom_addr` = {mode[3:0], address} in the request cycle. It returns `rom_rdata` one cycle later and then adds 1 to the address.
- R5: When a ROM-mode address is 0xFFFF before its increment, the address becomes 0 and the whole mode word increases by 1. The bank therefore carries instead of wrapping.
- R6: A context whose mode satisfies (mode & 0x43FF) == 0x0018 is in DRAM mode. Its step code is mode[13:11]: code 0 gives a step of 0, and code c gives a step of 2^(c-1). Reads through a DRAM read context, and writes through a DRAM write context, drive `dram_en` (with `dram_we` set for writes) at the pointer address and then add the step.
- R7: Committing a mode word that has all of bits 0xB800 set pulses `mode_err` for the one cycle after the commit and leaves that context unconfigured. A mode word of 0 also leaves the context unconfigured.
- R8: A data read whose read context is unconfigured returns the register's plain stored value. A data write not served by a DRAM write context stores the word as that plain value and touches no memory.
- R9: `rom_en` and `dram_en` are never high together, and setup-register accesses drive neither.
- R10: The read and write contexts of a data register are independent. Configuring or advancing one leaves the other's address and mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| sel_setup | input | 1 | 1 = setup register, 0 = data register |
| ptr_idx | input | IDX_W | Data register index (also the target of a mode commit) |
| wdata | input | 16 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 16 | Read data |
| mode_err | output | 1 | One-cycle pulse after an unsupported mode commit |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 16+BANK_W | ROM word address |
| rom_rdata | input | 16 | ROM data, one cycle after `rom_en` |
| dram_en | output | 1 | DRAM access strobe |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 16 | DRAM word address |
| dram_wdata | output | 16 | DRAM write data |
| dram_rdata | input | 16 | DRAM data, one cycle after a DRAM read |

## Verification
The bench walks a ROM pointer across 0xFFFF into the next bank. A design that wrapped the address there would repeat bank 2 instead of reaching bank 3. It also reads the setup register in the middle of a sequence and then writes a mode word. A design that did not flip the phase on that read would take the word as a fresh address, and the following ROM read would go to the wrong place. DRAM write and read contexts with a step of 4 are paired on one data register, which exposes a wrong step decode and any leak between the read and write contexts. An unsupported mode word is committed over a live context, and the bench confirms the error pulse and the fallback to plain storage with no memory strobe.

// File: rtl/pmem_ptr_pkg.sv
package pmem_ptr_pkg;
   localparam int unsigned WORD_W    = 16;
   localparam logic [15:0] DRAM_MASK = 16'h43FF;
   localparam logic [15:0] DRAM_SIG  = 16'h0018;
   localparam logic [15:0] BAD_MASK  = 16'hB800;
   localparam int unsigned CTX_BIT   = 10;
   localparam int unsigned STEP_LSB  = 11;
   localparam int unsigned STEP_W    = 3;

   typedef enum logic [1:0] {SRC_HOLD, SRC_ROM, SRC_DRAM} rsrc_e;

   function automatic logic mode_is_dram(input logic [15:0] m);
      return (m & DRAM_MASK) == DRAM_SIG;
   endfunction

   function automatic logic mode_is_bad(input logic [15:0] m);
      return (m & BAD_MASK) == BAD_MASK;
   endfunction

   function automatic logic [15:0] mode_step(input logic [15:0] m);
      logic [STEP_W-1:0] code;
      code = m[STEP_LSB +: STEP_W];
      return (code == '0) ? 16'd0 : (16'd1 << (code - 3'd1));
   endfunction
endpackage

// File: rtl/pmem_setup_seq.sv
module pmem_setup_seq
   import pmem_ptr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [WORD_W-1:0] wdata,
   output logic              commit,
   output logic [WORD_W-1:0] staged
);
   logic mode_phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_phase <= 1'b0;
         staged     <= '0;
      end else begin
         if (wr || rd) mode_phase <= ~mode_phase;
         if (wr && !mode_phase) staged <= wdata;
      end
   end

   assign commit = wr && mode_phase;

   // R3: every setup access flips the phase
   a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (wr || rd) |=> (mode_phase != $past(mode_phase)));
   // R2: phase holds without setup traffic
   a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !rd) |=> $stable(mode_phase));
   // R2: staged address only changes on an address-phase write
   a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && !mode_phase) |=> $stable(staged));
endmodule

// File: rtl/pmem_ptr_ctx.sv
module pmem_ptr_ctx
   import pmem_ptr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_mode,
   input  logic              adv,
   output logic [WORD_W-1:0] addr_o,
   output logic [WORD_W-1:0] mode_o,
   output logic              live_o,
   output logic              dram_o
);
   assign dram_o = live_o && mode_is_dram(mode_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
         mode_o <= '0;
         live_o <= 1'b0;
      end else if (load) begin
         addr_o <= load_addr;
         mode_o <= load_mode;
         live_o <= (load_mode != '0) && !mode_is_bad(load_mode);
      end else if (adv && live_o) begin
         if (dram_o) begin
            addr_o <= addr_o + mode_step(mode_o);
         end else if (addr_o == '1) begin
            addr_o <= '0;
            mode_o <= mode_o + 16'd1;
         end else begin
            addr_o <= addr_o + 16'd1;
         end
      end
   end

   a_r4_rom_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && live_o && !dram_o && addr_o != '1)
      |=> (addr_o == $past(addr_o) + 16'd1) && $stable(mode_o));
   a_r5_bank_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && live_o && !dram_o && addr_o == '1)
      |=> (addr_o == '0) && (mode_o == $past(mode_o) + 16'd1));
   a_r6_dram_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && dram_o)
      |=> (addr_o == $past(addr_o) + mode_step($past(mode_o))) && $stable(mode_o));
   a_r7_bad_unlive: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode_is_bad(load_mode)) |=> !live_o);
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(addr_o) && $stable(mode_o) && $stable(live_o));
endmodule

// File: rtl/pmem_ptr_ctrl.sv
module pmem_ptr_ctrl
   import pmem_ptr_pkg::*;
#(
   parameter int unsigned NUM_PTR = 3,
   parameter int unsigned BANK_W  = 4,
   localparam int unsigned IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
   localparam int unsigned RA_W   = WORD_W + BANK_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic              sel_setup,
   input  logic [IDX_W-1:0]  ptr_idx,
   input  logic [WORD_W-1:0] wdata,
   output logic              rvalid,
   output logic [WORD_W-1:0] rdata,
   output logic              mode_err,
   output logic              rom_en,
   output logic [RA_W-1:0]   rom_addr,
   input  logic [WORD_W-1:0] rom_rdata,
   output logic              dram_en,
   output logic              dram_we,
   output logic [WORD_W-1:0] dram_addr,
   output logic [WORD_W-1:0] dram_wdata,
   input  logic [WORD_W-1:0] dram_rdata
);
   localparam int unsigned CI_W   = IDX_W + 1;
   localparam int unsigned NSLOT  = 1 << CI_W;
   localparam int unsigned NCTX   = 2 * NUM_PTR;
   localparam int unsigned NREG   = 1 << IDX_W;

   if (NUM_PTR < 1 || NUM_PTR > 8) begin : g_bad_num
      $error("NUM_PTR must be 1..8");
   end
   if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank
      $error("BANK_W must be 1..8");
   end

   // request decode
   logic setup_rd, setup_wr, data_rd, data_wr, idx_ok;
   assign setup_rd = req && !we &&  sel_setup;
   assign setup_wr = req &&  we &&  sel_setup;
   assign data_rd  = req && !we && !sel_setup;
   assign data_wr  = req &&  we && !sel_setup;
   assign idx_ok   = 32'(ptr_idx) < NUM_PTR;

   logic [CI_W-1:0] k_rd, k_wr, k_load, last_k;
   assign k_rd = {ptr_idx, 1'b0};
   assign k_wr = {ptr_idx, 1'b1};

   // setup sequencer
   logic              commit;
   logic [WORD_W-1:0] staged;
   pmem_setup_seq u_seq (
      .clk(clk), .rst_n(rst_n), .wr(setup_wr), .rd(setup_rd),
      .wdata(wdata), .commit(commit), .staged(staged)
   );
   assign k_load = {ptr_idx, wdata[CTX_BIT]};

   // pointer contexts (even slot = read, odd slot = write)
   logic [WORD_W-1:0] c_addr [NSLOT];
   logic [WORD_W-1:0] c_mode [NSLOT];
   logic [NSLOT-1:0]  c_live, c_dram, c_load, c_adv;

   logic rom_go, dram_rd_go, dram_wr_go;

   for (genvar k = 0; k < NSLOT; k++) begin : g_ctx
      assign c_load[k] = commit && idx_ok && (k_load == CI_W'(k));
      assign c_adv[k]  = ((rom_go || dram_rd_go) && (k_rd == CI_W'(k))) ||
                         (dram_wr_go && (k_wr == CI_W'(k)));
      if (k < NCTX) begin : g_live
         pmem_ptr_ctx u_ctx (
            .clk(clk), .rst_n(rst_n),
            .load(c_load[k]), .load_addr(staged), .load_mode(wdata),
            .adv(c_adv[k]),
            .addr_o(c_addr[k]), .mode_o(c_mode[k]),
            .live_o(c_live[k]), .dram_o(c_dram[k])
         );
      end else begin : g_tie
         assign c_addr[k] = '0;
         assign c_mode[k] = '0;
         assign c_live[k] = 1'b0;
         assign c_dram[k] = 1'b0;
      end
   end

   // memory routing
   assign rom_go     = data_rd && idx_ok && c_live[k_rd] && !c_dram[k_rd];
   assign dram_rd_go = data_rd && idx_ok && c_dram[k_rd];
   assign dram_wr_go = data_wr && idx_ok && c_dram[k_wr];

   assign rom_en     = rom_go;
   assign rom_addr   = {c_mode[k_rd][BANK_W-1:0], c_addr[k_rd]};
   assign dram_en    = dram_rd_go || dram_wr_go;
   assign dram_we    = dram_wr_go;
   assign dram_addr  = dram_wr_go ? c_addr[k_wr] : c_addr[k_rd];
   assign dram_wdata = wdata;

   // plain storage per data register
   logic [WORD_W-1:0] plain [NREG];
   for (genvar p = 0; p < NREG; p++) begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)
            plain[p] <= '0;
         else if (data_wr && idx_ok && !dram_wr_go && (ptr_idx == IDX_W'(p)))
            plain[p] <= wdata;
      end
   end

   // response path and last-accessed tracking
   rsrc_e             src_q;
   logic [WORD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid   <= 1'b0;
         src_q    <= SRC_HOLD;
         hold_q   <= '0;
         last_k   <= '0;
         mode_err <= 1'b0;
      end else begin
         rvalid   <= setup_rd || data_rd;
         mode_err <= commit && mode_is_bad(wdata);
         src_q    <= rom_go ? SRC_ROM : (dram_rd_go ? SRC_DRAM : SRC_HOLD);
         if (setup_rd)
            hold_q <= c_addr[last_k];
         else if (data_rd)
            hold_q <= idx_ok ? plain[ptr_idx] : '0;
         if (data_rd && idx_ok)       last_k <= k_rd;
         else if (data_wr && idx_ok)  last_k <= k_wr;
         else if (commit && idx_ok)   last_k <= k_load;
      end
   end

   always_comb begin
      unique case (src_q)
         SRC_ROM:  rdata = rom_rdata;
         SRC_DRAM: rdata = dram_rdata;
         default:  rdata = hold_q;
      endcase
   end

   a_r9_one_memory: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_en && dram_en));
   a_r9_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req && sel_setup) |-> (!rom_en && !dram_en));
   a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we) |=> rvalid);
   a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(c_load));
   a_r8_write_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we) |-> !rom_en);
endmodule

// File: tb/tb_pmem_ptr_ctrl.sv
module tb_pmem_ptr_ctrl;
   localparam int NUM_PTR = 3;
   localparam int BANK_W  = 4;
   localparam int IDX_W   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, we = 1'b0, sel_setup = 1'b0;
   logic [IDX_W-1:0] ptr_idx = '0;
   logic [15:0] wdata = '0;
   logic rvalid, mode_err, rom_en, dram_en, dram_we;
   logic [15:0] rdata, dram_addr, dram_wdata;
   logic [19:0] rom_addr;
   logic [15:0] rom_rdata = '0, dram_rdata = '0;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pmem_ptr_ctrl #(.NUM_PTR(NUM_PTR), .BANK_W(BANK_W)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sel_setup(sel_setup),
      .ptr_idx(ptr_idx), .wdata(wdata), .rvalid(rvalid), .rdata(rdata),
      .mode_err(mode_err), .rom_en(rom_en), .rom_addr(rom_addr),
      .rom_rdata(rom_rdata), .dram_en(dram_en), .dram_we(dram_we),
      .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
   );

   function automatic logic [15:0] rom_f(input logic [19:0] a);
      return a[15:0] ^ {a[19:16], 12'h3C5};
   endfunction

   // memory models
   logic [15:0] dmem [int];
   always @(posedge clk) begin
      if (rom_en) rom_rdata <= rom_f(rom_addr);
      if (dram_en) begin
         if (dram_we) dmem[int'(dram_addr)] = dram_wdata;
         else dram_rdata <= dmem.exists(int'(dram_addr)) ? dmem[int'(dram_addr)] : ~dram_addr;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            check(0, "R3 unexpected rvalid", {4'h0, rdata}, 20'h0);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata == e, t, {4'h0, rdata}, {4'h0, e});
         end
      end
   end

   task automatic op(input logic w, input logic s, input int idx, input logic [15:0] d);
      @(negedge clk);
      req = 1'b1; we = w; sel_setup = s; ptr_idx = IDX_W'(idx); wdata = d;
   endtask

   task automatic idle();
      @(negedge clk);
      req = 1'b0; we = 1'b0; sel_setup = 1'b0;
   endtask

   task automatic rd_setup(input logic [15:0] e, input string t);
      op(0, 1, 0, 16'h0);
      exp_q.push_back(e); tag_q.push_back(t);
      #1 check(!rom_en && !dram_en, "R9 setup read drives memory", {18'h0, rom_en, dram_en}, 20'h0);
   endtask

   task automatic wr_setup(input int idx, input logic [15:0] d);
      op(1, 1, idx, d);
      #1 check(!rom_en && !dram_en, "R9 setup write drives memory", {18'h0, rom_en, dram_en}, 20'h0);
   endtask

   task automatic rd_rom(input int idx, input logic [19:0] a, input string t);
      op(0, 0, idx, 16'h0);
      exp_q.push_back(rom_f(a)); tag_q.push_back(t);
      #1 check(rom_en && !dram_en && rom_addr == a, t, rom_addr, a);
   endtask

   task automatic rd_dram(input int idx, input logic [15:0] a, input logic [15:0] e, input string t);
      op(0, 0, idx, 16'h0);
      exp_q.push_back(e); tag_q.push_back(t);
      #1 check(dram_en && !dram_we && !rom_en && dram_addr == a, t, {4'h0, dram_addr}, {4'h0, a});
   endtask

   task automatic rd_plain(input int idx, input logic [15:0] e, input string t);
      op(0, 0, idx, 16'h0);
      exp_q.push_back(e); tag_q.push_back(t);
      #1 check(!rom_en && !dram_en, {t, " memory strobe"}, {18'h0, rom_en, dram_en}, 20'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(0, "watchdog expired", 20'h0, 20'h1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!rvalid && !rom_en && !dram_en && !mode_err, "R1 outputs idle in reset",
            {16'h0, rvalid, rom_en, dram_en, mode_err}, 20'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!rvalid && !rom_en && !dram_en && !mode_err, "R1 outputs idle after reset",
            {16'h0, rvalid, rom_en, dram_en, mode_err}, 20'h0);
      rd_setup(16'h0000, "R1 last context address after reset");
      rd_setup(16'h0000, "R1 second setup read restores phase");

      // R8 plain storage
      rd_plain(1, 16'h0000, "R8 unconfigured read returns plain reset value");
      op(1, 0, 1, 16'h1234);
      #1 check(!rom_en && !dram_en, "R8 plain write touches no memory", {18'h0, rom_en, dram_en}, 20'h0);
      rd_plain(1, 16'h1234, "R8 plain value read back");

      // R2 / R4 ROM pointer, bank 3
      wr_setup(0, 16'h0100);
      wr_setup(0, 16'h0003);
      idle();
      check(!mode_err, "R7 no error on valid mode", {19'h0, mode_err}, 20'h0);
      rd_rom(0, 20'h30100, "R4 ROM read first address");
      rd_rom(0, 20'h30101, "R4 ROM read incremented address");

      // R3 setup read toggles phase; next write is a mode commit
      rd_setup(16'h0102, "R3 setup read returns last address");
      wr_setup(2, 16'h0005);
      rd_rom(2, 20'h50100, "R3 write after setup read commits staged address");
      rd_setup(16'h0101, "R3 last context follows data read");
      rd_setup(16'h0101, "R3 repeated setup read");

      // R5 bank carry
      wr_setup(0, 16'hFFFE);
      wr_setup(1, 16'h0002);
      rd_rom(1, 20'h2FFFE, "R5 before top");
      rd_rom(1, 20'h2FFFF, "R5 at top");
      rd_rom(1, 20'h30000, "R5 bank carried");
      rd_rom(1, 20'h30001, "R5 continues in new bank");
      rd_setup(16'h0002, "R5 address after carry");
      rd_setup(16'h0002, "R5 address after carry again");

      // R6 DRAM write context, step code 3 -> step 4, bit 10 = write context
      wr_setup(0, 16'h0200);
      wr_setup(1, 16'h1C18);
      op(1, 0, 1, 16'hAAAA);
      #1 check(dram_en && dram_we && !rom_en && dram_addr == 16'h0200 && dram_wdata == 16'hAAAA,
               "R6 DRAM write first", {4'h0, dram_addr}, 20'h00200);
      op(1, 0, 1, 16'hBBBB);
      #1 check(dram_en && dram_we && dram_addr == 16'h0204 && dram_wdata == 16'hBBBB,
               "R6 DRAM write stepped by 4", {4'h0, dram_addr}, 20'h00204);
      rd_setup(16'h0208, "R3 last context follows data write");
      rd_setup(16'h0208, "R3 last context follows data write again");
      rd_rom(1, 20'h30002, "R10 read context unaffected by write context");

      // R6 DRAM read context with step 4
      wr_setup(0, 16'h0200);
      wr_setup(0, 16'h1818);
      rd_dram(0, 16'h0200, 16'hAAAA, "R6 DRAM read first");
      rd_dram(0, 16'h0204, 16'hBBBB, "R6 DRAM read stepped");
      rd_dram(0, 16'h0208, 16'hFDF7, "R6 DRAM read unwritten word");

      // R7 unsupported mode over live context 2
      wr_setup(0, 16'h0010);
      wr_setup(2, 16'hB800);
      idle();
      check(mode_err, "R7 error pulse after bad mode", {19'h0, mode_err}, 20'h1);
      idle();
      check(!mode_err, "R7 error pulse lasts one cycle", {19'h0, mode_err}, 20'h0);
      rd_plain(2, 16'h0000, "R7 bad mode leaves context unconfigured");

      // R8 plain write on register without write context
      op(1, 0, 2, 16'h7777);
      #1 check(!rom_en && !dram_en, "R8 plain write no strobe", {18'h0, rom_en, dram_en}, 20'h0);
      rd_plain(2, 16'h7777, "R8 plain write read back");

      idle(); idle(); idle();
      check(exp_q.size() == 0, "R3 all responses seen", 20'(exp_q.size()), 20'h0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule